// File: doc/BRIEF.md
# Runahead Mode Controller

This block keeps a core doing useful work while its oldest instruction waits on a long-latency last-level miss. Instead of stalling, the controller saves every architectural register into a shadow copy in one cycle and switches into a speculative mode. In that mode, instructions keep flowing through its register-write port. A per-register poison bit marks every value that depends on the outstanding miss. Loads whose address register is still trustworthy become prefetch requests. Loads with a poisoned address, and all stores, leave nothing behind.

When the blocking miss comes back, the controller spends exactly one cycle copying the shadow registers back and clearing every poison bit. It then returns to normal operation, so the core resumes from the checkpointed state. The pipeline, the caches and branch prediction are outside this block. The core presents each retiring instruction as an opcode, a destination, two source indices and a result value. It also presents a head-of-window miss flag, with the destination of the blocking load, and a miss-return pulse.

The mode is visible as a two-bit code: 0 normal, 1 speculative, 2 restore. An observation read port exposes any register's current value.

Top module: `runahead_ctrl`

## Requirements
- R1: After reset, the mode is 0 (normal), every register reads 0 and all poison bits are clear.
- R2: In normal mode, a valid instruction with opcode 0 (compute) or 1 (load) writes its data into its destination register at the next edge. Opcode 2 (store) raises st_commit in the same cycle and writes no register. pf_valid stays low in normal mode.
- R3: With head_miss high in normal mode, ckpt_take is high in that cycle and the mode is 1 from the next edge. All registers are captured into the checkpoint at that edge, and the instruction port is ignored in that cycle.
- R4: On entry, the only poison bit set is the one of the blocking load's destination head_dst.
- R5: In speculative mode, a compute result is poisoned when either source is poisoned, and a load result is poisoned when its address source (src_a) is poisoned. A poisoned result leaves the register value unchanged and sets its poison bit. A clean result writes the value and clears the poison bit.
- R6: In speculative mode, a load whose src_a is clean raises pf_valid in the same cycle, with pf_addr equal to that register's current value. A load with a poisoned src_a raises no request.
- R7: In speculative mode, a store never raises st_commit and changes no register.
- R8: With miss_ret high in speculative mode, the mode is 2 from the next edge, and the instruction port is ignored in the return cycle. head_miss has no effect in speculative mode.
- R9: The restore mode lasts one cycle with ckpt_restore high. At its edge every register takes its checkpoint value, all poison bits clear and the mode returns to 0. No instruction is written in that cycle.
- R10: miss_ret has no effect in normal mode or in restore mode.
- R11: src_inv_a and src_inv_b show, combinationally, the poison bits of ins_src_a and ins_src_b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| head_miss | input | 1 | Oldest instruction is a long-latency last-level miss |
| head_dst | input | 4 | Destination register of the blocking load |
| miss_ret | input | 1 | The blocking miss has returned |
| ins_valid | input | 1 | Instruction present on the write port |
| ins_op | input | 2 | 0 compute, 1 load, 2 store, 3 none |
| ins_dst | input | 4 | Destination register index |
| ins_src_a | input | 4 | First source index (load address register) |
| ins_src_b | input | 4 | Second source index |
| ins_data | input | 32 | Result value to write |
| src_inv_a | output | 1 | Poison bit of ins_src_a |
| src_inv_b | output | 1 | Poison bit of ins_src_b |
| pf_valid | output | 1 | Prefetch request |
| pf_addr | output | 32 | Prefetch address |
| st_commit | output | 1 | Store may update architectural memory |
| ckpt_take | output | 1 | Checkpoint captured at this edge |
| ckpt_restore | output | 1 | Checkpoint restored at this edge |
| mode | output | 2 | 0 normal, 1 speculative, 2 restore |
| inv_vec | output | 16 | Poison bit of every register |
| obs_idx | input | 4 | Observation read index |
| obs_data | output | 32 | Value of register obs_idx |

## Verification
The assertions check the mode sequence on every cycle: entry on a head miss, restore after a return, a single restore cycle, and return and entry requests that are ignored. They also check that no prefetch or store commit leaves the wrong mode, that no register is written during restore, and that poison bits are clear in normal mode. Only the bench scenarios can show the values themselves. That covers poison chains through several instructions, re-cleaning of a poisoned register, the prefetch addresses, and the register file matching the checkpoint after roll-back and not the speculative writes.

// File: rtl/ra_pkg.sv
package ra_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL  = 2'd0,
    MODE_AHEAD   = 2'd1,
    MODE_RESTORE = 2'd2
  } ra_mode_e;

  typedef enum logic [1:0] {
    OP_ALU   = 2'd0,
    OP_LOAD  = 2'd1,
    OP_STORE = 2'd2,
    OP_NONE  = 2'd3
  } ra_op_e;

  // Poison of a result given the poison of its sources.
  function automatic logic result_poison(input ra_op_e op, input logic pa, input logic pb);
    case (op)
      OP_ALU:  return pa | pb;
      OP_LOAD: return pa;
      default: return 1'b0;
    endcase
  endfunction

  // Whether an opcode produces a register result.
  function automatic logic op_writes(input ra_op_e op);
    return (op == OP_ALU) || (op == OP_LOAD);
  endfunction

endpackage

// File: rtl/ra_mode_fsm.sv
module ra_mode_fsm
  import ra_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     head_miss,
  input  logic     miss_ret,
  output ra_mode_e mode_q,
  output logic     enter_evt,
  output logic     return_evt,
  output logic     restore_evt
);
  ra_mode_e mode_d;

  assign enter_evt   = (mode_q == MODE_NORMAL) && head_miss;
  assign return_evt  = (mode_q == MODE_AHEAD) && miss_ret;
  assign restore_evt = (mode_q == MODE_RESTORE);

  always_comb begin
    mode_d = mode_q;
    case (mode_q)
      MODE_NORMAL:  if (head_miss) mode_d = MODE_AHEAD;
      MODE_AHEAD:   if (miss_ret)  mode_d = MODE_RESTORE;
      MODE_RESTORE: mode_d = MODE_NORMAL;
      default:      mode_d = MODE_NORMAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_NORMAL;
    else        mode_q <= mode_d;
  end
endmodule

// File: rtl/ra_arch_regs.sv
module ra_arch_regs #(
  parameter int NREG = 16,
  parameter int XLEN = 32,
  localparam int IDXW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [XLEN-1:0] wr_data,
  input  logic            take_ckpt,
  input  logic            do_restore,
  input  logic [IDXW-1:0] rd_idx_a,
  output logic [XLEN-1:0] rd_data_a,
  input  logic [IDXW-1:0] rd_idx_b,
  output logic [XLEN-1:0] rd_data_b
);
  logic [XLEN-1:0] live_view [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_cell
    logic [XLEN-1:0] live_q;
    logic [XLEN-1:0] shadow_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        live_q   <= '0;
        shadow_q <= '0;
      end else begin
        if (do_restore)                          live_q <= shadow_q;
        else if (wr_en && wr_idx == IDXW'(g))    live_q <= wr_data;
        if (take_ckpt)                           shadow_q <= live_q;
      end
    end

    assign live_view[g] = live_q;
  end

  assign rd_data_a = live_view[rd_idx_a];
  assign rd_data_b = live_view[rd_idx_b];
endmodule

// File: rtl/ra_poison_track.sv
module ra_poison_track #(
  parameter int NREG = 16,
  localparam int IDXW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            seed,
  input  logic [IDXW-1:0] seed_idx,
  input  logic            clear,
  input  logic            upd_en,
  input  logic [IDXW-1:0] upd_idx,
  input  logic            upd_val,
  input  logic [IDXW-1:0] look_a,
  input  logic [IDXW-1:0] look_b,
  output logic            hit_a,
  output logic            hit_b,
  output logic [NREG-1:0] poison_vec
);
  for (genvar g = 0; g < NREG; g++) begin : g_bit
    logic bit_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  bit_q <= 1'b0;
      else if (clear)                              bit_q <= 1'b0;
      else if (seed)                               bit_q <= (seed_idx == IDXW'(g));
      else if (upd_en && upd_idx == IDXW'(g))      bit_q <= upd_val;
    end

    assign poison_vec[g] = bit_q;
  end

  assign hit_a = poison_vec[look_a];
  assign hit_b = poison_vec[look_b];
endmodule

// File: rtl/runahead_ctrl.sv
module runahead_ctrl
  import ra_pkg::*;
#(
  parameter int NREG = 16,
  parameter int XLEN = 32,
  localparam int IDXW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            head_miss,
  input  logic [IDXW-1:0] head_dst,
  input  logic            miss_ret,
  input  logic            ins_valid,
  input  logic [1:0]      ins_op,
  input  logic [IDXW-1:0] ins_dst,
  input  logic [IDXW-1:0] ins_src_a,
  input  logic [IDXW-1:0] ins_src_b,
  input  logic [XLEN-1:0] ins_data,
  output logic            src_inv_a,
  output logic            src_inv_b,
  output logic            pf_valid,
  output logic [XLEN-1:0] pf_addr,
  output logic            st_commit,
  output logic            ckpt_take,
  output logic            ckpt_restore,
  output logic [1:0]      mode,
  output logic [NREG-1:0] inv_vec,
  input  logic [IDXW-1:0] obs_idx,
  output logic [XLEN-1:0] obs_data
);
  ra_mode_e mode_q;
  logic     enter_evt, return_evt, restore_evt;
  logic     in_normal, in_ahead;
  logic     ins_live;
  ra_op_e   op;
  logic     dst_poison;
  logic     wr_en;
  logic     poison_upd;
  logic     pa, pb;
  logic [XLEN-1:0] addr_val;

  ra_mode_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .head_miss  (head_miss),
    .miss_ret   (miss_ret),
    .mode_q     (mode_q),
    .enter_evt  (enter_evt),
    .return_evt (return_evt),
    .restore_evt(restore_evt)
  );

  assign in_normal = (mode_q == MODE_NORMAL);
  assign in_ahead  = (mode_q == MODE_AHEAD);
  assign op        = ra_op_e'(ins_op);

  // The port is live only outside the entry, return and restore cycles.
  assign ins_live   = ins_valid && ((in_normal && !enter_evt) || (in_ahead && !return_evt));
  assign dst_poison = in_ahead && result_poison(op, pa, pb);
  assign wr_en      = ins_live && op_writes(op) && !dst_poison;
  assign poison_upd = ins_live && in_ahead && op_writes(op);

  ra_arch_regs #(.NREG(NREG), .XLEN(XLEN)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_idx    (ins_dst),
    .wr_data   (ins_data),
    .take_ckpt (enter_evt),
    .do_restore(restore_evt),
    .rd_idx_a  (ins_src_a),
    .rd_data_a (addr_val),
    .rd_idx_b  (obs_idx),
    .rd_data_b (obs_data)
  );

  ra_poison_track #(.NREG(NREG)) u_poison (
    .clk       (clk),
    .rst_n     (rst_n),
    .seed      (enter_evt),
    .seed_idx  (head_dst),
    .clear     (restore_evt),
    .upd_en    (poison_upd),
    .upd_idx   (ins_dst),
    .upd_val   (dst_poison),
    .look_a    (ins_src_a),
    .look_b    (ins_src_b),
    .hit_a     (pa),
    .hit_b     (pb),
    .poison_vec(inv_vec)
  );

  assign src_inv_a    = pa;
  assign src_inv_b    = pb;
  assign pf_valid     = ins_live && in_ahead && (op == OP_LOAD) && !pa;
  assign pf_addr      = addr_val;
  assign st_commit    = ins_live && in_normal && (op == OP_STORE);
  assign ckpt_take    = enter_evt;
  assign ckpt_restore = restore_evt;
  assign mode         = mode_q;
endmodule

// File: rtl/ra_ctrl_chk.sv
module ra_ctrl_chk #(
  parameter int NREG = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      mode,
  input logic            head_miss,
  input logic            miss_ret,
  input logic            pf_valid,
  input logic            st_commit,
  input logic            wr_en,
  input logic [NREG-1:0] inv_vec
);
  // R1
  legal_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'd3);

  // R3
  enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && head_miss) |=> (mode == 2'd1));

  // R4
  seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && head_miss) |=> ($countones(inv_vec) == 1));

  // R8
  return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && miss_ret) |=> (mode == 2'd2));

  // R8
  stay_ahead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && !miss_ret) |=> (mode == 2'd1));

  // R9
  one_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2) |=> (mode == 2'd0 && inv_vec == '0));

  // R9
  no_write_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2) |-> !wr_en);

  // R10
  ignore_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && !head_miss) |=> (mode == 2'd0));

  // R6
  pf_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> (mode == 2'd1));

  // R7
  st_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_commit |-> (mode == 2'd0));

  // R2
  clean_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0) |-> (inv_vec == '0));
endmodule

bind runahead_ctrl ra_ctrl_chk #(.NREG(NREG)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mode     (mode),
  .head_miss(head_miss),
  .miss_ret (miss_ret),
  .pf_valid (pf_valid),
  .st_commit(st_commit),
  .wr_en    (wr_en),
  .inv_vec  (inv_vec)
);

// File: tb/runahead_ctrl_tb.sv
`timescale 1ns/1ps
module runahead_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        head_miss = 1'b0;
  logic [3:0]  head_dst = '0;
  logic        miss_ret = 1'b0;
  logic        ins_valid = 1'b0;
  logic [1:0]  ins_op = 2'd3;
  logic [3:0]  ins_dst = '0, ins_src_a = '0, ins_src_b = '0;
  logic [31:0] ins_data = '0;
  logic        src_inv_a, src_inv_b, pf_valid, st_commit, ckpt_take, ckpt_restore;
  logic [31:0] pf_addr, obs_data;
  logic [1:0]  mode;
  logic [15:0] inv_vec;
  logic [3:0]  obs_idx = '0;

  runahead_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .head_miss(head_miss), .head_dst(head_dst),
    .miss_ret(miss_ret), .ins_valid(ins_valid), .ins_op(ins_op), .ins_dst(ins_dst),
    .ins_src_a(ins_src_a), .ins_src_b(ins_src_b), .ins_data(ins_data),
    .src_inv_a(src_inv_a), .src_inv_b(src_inv_b), .pf_valid(pf_valid), .pf_addr(pf_addr),
    .st_commit(st_commit), .ckpt_take(ckpt_take), .ckpt_restore(ckpt_restore),
    .mode(mode), .inv_vec(inv_vec), .obs_idx(obs_idx), .obs_data(obs_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct { bit is_pf; logic [31:0] addr; string req; } exp_t;
  exp_t sb_q[$];

  // Reference state built from the requirements.
  logic [31:0] m_reg [NR];
  logic [31:0] m_ck  [NR];
  logic [15:0] m_inv;
  int          m_mode;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Monitor: pops expected prefetches and store commits.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && (pf_valid || st_commit)) begin
        if (sb_q.size() == 0) begin
          check(1'b0, pf_valid ? "R6" : "R7", "unexpected request", {31'd0, pf_valid}, 32'd0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check(e.is_pf == pf_valid, e.req, "request kind", {31'd0, pf_valid}, {31'd0, e.is_pf});
          if (e.is_pf) check(pf_addr == e.addr, e.req, "prefetch address", pf_addr, e.addr);
        end
      end
    end
  end

  // Driver: one cycle of stimulus, with expectations from the reference state.
  task automatic step(input bit hm, input logic [3:0] hd, input bit mr, input bit iv,
                      input logic [1:0] op, input logic [3:0] d, input logic [3:0] a,
                      input logic [3:0] b, input logic [31:0] data, input string req);
    bit live, pois;
    @(posedge clk); #1;
    check(mode == 2'(m_mode), req, "mode", {30'd0, mode}, m_mode);
    check(inv_vec == m_inv, req, "poison vector", {16'd0, inv_vec}, {16'd0, m_inv});
    head_miss = hm; head_dst = hd; miss_ret = mr; ins_valid = iv; ins_op = op;
    ins_dst = d; ins_src_a = a; ins_src_b = b; ins_data = data;
    #1;
    // R11
    check(src_inv_a == m_inv[a] && src_inv_b == m_inv[b], "R11", "source lookup",
          {30'd0, src_inv_a, src_inv_b}, {30'd0, m_inv[a], m_inv[b]});
    check(ckpt_take == (m_mode == 0 && hm), "R3", "ckpt_take", ckpt_take, (m_mode == 0 && hm));
    check(ckpt_restore == (m_mode == 2), "R9", "ckpt_restore", ckpt_restore, (m_mode == 2));
    live = iv && ((m_mode == 0 && !hm) || (m_mode == 1 && !mr));
    if (live && m_mode == 1 && op == 2'd1 && !m_inv[a]) sb_q.push_back('{1'b1, m_reg[a], req});
    if (live && m_mode == 0 && op == 2'd2) sb_q.push_back('{1'b0, 32'd0, req});
    case (m_mode)
      0: begin
        if (hm) begin
          for (int i = 0; i < NR; i++) m_ck[i] = m_reg[i];
          m_inv = 16'd1 << hd;
          m_mode = 1;
        end else if (live && op <= 2'd1) m_reg[d] = data;
      end
      1: begin
        if (mr) m_mode = 2;
        else if (live && op <= 2'd1) begin
          pois = (op == 2'd0) ? (m_inv[a] | m_inv[b]) : m_inv[a];
          if (pois) m_inv[d] = 1'b1;
          else begin m_reg[d] = data; m_inv[d] = 1'b0; end
        end
      end
      default: begin
        for (int i = 0; i < NR; i++) m_reg[i] = m_ck[i];
        m_inv = '0;
        m_mode = 0;
      end
    endcase
  endtask

  task automatic idle(input string req);
    step(0, 0, 0, 0, 2'd3, 0, 0, 0, 0, req);
  endtask

  // Idle cycle that also reads every register through the observation port.
  task automatic check_regs(input string req);
    @(posedge clk); #1;
    head_miss = 0; miss_ret = 0; ins_valid = 0; ins_op = 2'd3;
    for (int i = 0; i < NR; i++) begin
      obs_idx = 4'(i);
      #0.2;
      check(obs_data == m_reg[i], req, $sformatf("register %0d", i), obs_data, m_reg[i]);
    end
    check(mode == 2'(m_mode), req, "mode", {30'd0, mode}, m_mode);
    if (m_mode == 2) begin
      for (int i = 0; i < NR; i++) m_reg[i] = m_ck[i];
      m_inv = '0; m_mode = 0;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 4000);
    if (!finished) begin
      check(1'b0, "ALL", "watchdog expired", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NR; i++) begin m_reg[i] = '0; m_ck[i] = '0; end
    m_inv = '0; m_mode = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    check_regs("R1");
    // R2: normal writes, store commit, no prefetch.
    step(0, 0, 0, 1, 2'd0, 4'd1, 0, 0, 32'h0000_0100, "R2");
    step(0, 0, 0, 1, 2'd1, 4'd2, 0, 0, 32'h0000_0200, "R2");
    step(0, 0, 0, 1, 2'd0, 4'd3, 0, 0, 32'h0000_0005, "R2");
    step(0, 0, 0, 1, 2'd0, 4'd9, 0, 0, 32'h0000_0999, "R2");
    step(0, 0, 0, 1, 2'd2, 4'd3, 4'd1, 0, 32'hdead_beef, "R2");
    // R10: return in normal mode ignored.
    step(0, 0, 1, 0, 2'd3, 0, 0, 0, 0, "R10");
    check_regs("R2");

    // R3 R4: entry with a write offered in the same cycle (ignored).
    step(1, 4'd4, 0, 1, 2'd0, 4'd1, 0, 0, 32'h1111_1111, "R3");
    check_regs("R3");
    // R5 R6 R7 in speculative mode.
    step(0, 0, 0, 1, 2'd0, 4'd5, 4'd4, 4'd1, 32'h55, "R5");
    step(0, 0, 0, 1, 2'd1, 4'd6, 4'd1, 0, 32'h66, "R6");
    step(0, 0, 0, 1, 2'd1, 4'd7, 4'd5, 0, 32'h77, "R6");
    step(0, 0, 0, 1, 2'd0, 4'd8, 4'd2, 4'd7, 32'h88, "R5");
    step(0, 0, 0, 1, 2'd0, 4'd1, 4'd2, 4'd3, 32'h0000_0abc, "R5");
    step(0, 0, 0, 1, 2'd1, 4'd10, 4'd1, 0, 32'h10, "R6");
    step(0, 0, 0, 1, 2'd2, 4'd0, 4'd1, 0, 32'hffff_ffff, "R7");
    step(0, 0, 0, 1, 2'd0, 4'd5, 4'd2, 4'd2, 32'h5555, "R5");
    // R8: head_miss in speculative mode ignored.
    step(1, 4'd12, 0, 0, 2'd3, 0, 0, 0, 0, "R8");
    check_regs("R5");
    // R8 R9: return with a write offered (ignored), then restore with a write offered.
    step(0, 0, 1, 1, 2'd0, 4'd11, 0, 0, 32'hbad0, "R8");
    step(0, 0, 1, 1, 2'd0, 4'd12, 0, 0, 32'hbad1, "R9");
    check_regs("R9");

    // Second episode: chain from register 0, prefetch from checkpointed value.
    step(0, 0, 0, 1, 2'd1, 4'd2, 0, 0, 32'h0000_4000, "R2");
    step(1, 4'd0, 0, 0, 2'd3, 0, 0, 0, 0, "R4");
    step(0, 0, 0, 1, 2'd0, 4'd3, 4'd0, 4'd0, 32'h33, "R5");
    step(0, 0, 0, 1, 2'd1, 4'd4, 4'd3, 0, 32'h44, "R6");
    step(0, 0, 0, 1, 2'd1, 4'd6, 4'd2, 0, 32'h46, "R6");
    step(0, 0, 0, 1, 2'd0, 4'd0, 4'd9, 4'd9, 32'h1234, "R5");
    step(0, 0, 0, 1, 2'd1, 4'd7, 4'd0, 0, 32'h47, "R6");
    step(0, 0, 1, 0, 2'd3, 0, 0, 0, 0, "R8");
    check_regs("R9");
    idle("R1");
    repeat (2) @(posedge clk);

    check(sb_q.size() == 0, "R6", "pending expected requests", sb_q.size(), 0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule